// File: doc/BRIEF.md
# Extended Operand Address and Fetch Unit

This unit is the addressing stage of a 24-bit word, 1-megabyte processor. When `start` is pulsed it decodes the first bytes of an instruction. Six flag bits pick the format and compute a 20-bit target address:

- direct;
- base-relative;
- PC-relative;
- the 4-byte extended form;
- the legacy 15-bit form.

The target address may be indexed.

The unit then delivers a 24-bit operand in one of three ways:

- it takes the address itself as an immediate value;
- it reads the word at the address, byte by byte, from a byte-wide asynchronous memory port;
- it reads a pointer word first and then reads the word the pointer names.

When the result is ready the unit pulses `done`. Flag combinations that are not allowed raise `err` together with `done`, and no memory access takes place. Executing the instruction is left to the next stage.

Top module: `ext_operand_fetch`

## Requirements
- R1: After reset, `done`, `err` and `memRd` are low.
- R2: The instruction layout is as follows. `instr[31:24]` is the first byte, with n = bit 25 and i = bit 24. The remaining flags are x = bit 23, b = bit 22, p = bit 21 and e = bit 20. The 12-bit displacement is `instr[19:8]`. With n=i=1, b=p=e=0, the target address is the displacement zero-extended, plus the low 20 bits of `indexReg` when x=1. The operand is the word at that address: three byte reads at address, address+1 and address+2 (modulo 2^20), with the lowest address as the most significant byte. `done` is high during the cycle after the third clock edge following the edge that samples `start`.
- R3: With b=1, p=0, e=0, the target address is the low 20 bits of `baseReg` plus the displacement, which is taken as unsigned (0 to 4095).
- R4: With b=0, p=1, e=0, the target address is `pc` + 3 + the displacement sign-extended from 12 bits, modulo 2^20.
- R5: With e=1 and b=p=0, the target address is the 20-bit field `instr[19:0]`, plus the index when x=1.
- R6: With i=1, n=0, the operand is the target address zero-extended to 24 bits. `memRd` stays low, and `done` is high in the cycle right after the edge that samples `start`.
- R7: With n=1, i=0, the unit reads the word at the target address and uses its low 20 bits as the address of a second word read. That second word is the operand. `done` comes six edges after the sampling edge.
- R8: With n=i=0, `instr[22:8]` is a 15-bit address, indexed when x=1. The operand is read as in R2.
- R9: The following combinations are illegal: x=1 with immediate or indirect; b=p=1; e=1 together with b or p. An illegal combination in the new formats raises `err` and `done` in the cycle after the sampling edge, gives an operand of 0 and performs no memory read.
- R10: A `start` pulse that arrives while a fetch is in progress is ignored. The running fetch completes with its own results, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `instr` (one-cycle pulse) |
| instr | input | 32 | Instruction bytes, first byte in bits 31:24 |
| pc | input | 20 | Address of the current instruction |
| baseReg | input | 24 | Base register |
| indexReg | input | 24 | Index register |
| memRd | output | 1 | Memory byte read request |
| memAddr | output | 20 | Memory byte address |
| memData | input | 8 | Byte at `memAddr`, valid in the same cycle |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Illegal flag combination, valid with `done` |
| targetAddr | output | 20 | Computed target address, valid with `done` |
| operand | output | 24 | Operand value, valid with `done` |

## Verification
Counted from the rising edge that samples `start`, `done` is due at three different points:

- right after that edge for immediate and illegal instructions;
- three edges later for a simple read;
- six edges later for an indirect read.

Each scenario samples on falling edges and records the index of the first falling edge with `done` high. The check compares that index with the expected latency, and the address and operand are compared in that same cycle. `memRd` is sampled on every falling edge before `done`, which shows whether any memory access was made.

// File: rtl/ext_fetch_pkg.sv
package ext_fetch_pkg;
  typedef struct packed {
    logic load;     // latch address and mode from instr
    logic capByte;  // shift in one memory byte
    logic chain;    // pointer word complete: re-aim read address
  } fetchStrobes_t;
endpackage

// File: rtl/ext_fetch_datapath.sv
module ext_fetch_datapath
  import ext_fetch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 24,
  parameter int INSTR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [WORD_W-1:0]   baseReg,
  input  logic [WORD_W-1:0]   indexReg,
  input  logic [7:0]          memData,
  input  fetchStrobes_t       strb,
  output logic                modeImm,
  output logic                modeInd,
  output logic                illegal,
  output logic                lastByte,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   targetAddr,
  output logic [WORD_W-1:0]   operand
);
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int DISP_W = 12;
  localparam int OLD_W  = 15;
  localparam int FMT3_LEN = 3;

  logic fN, fI, fX, fB, fP, fE, oldFmt;
  logic [DISP_W-1:0] disp;
  logic [OLD_W-1:0]  oldAddr;
  logic [ADDR_W-1:0] rawAddr, idxAdd, taNext;
  logic [ADDR_W-1:0] taReg, ptrReg;
  logic [WORD_W-1:0] wordReg, wordNext;
  logic [OFF_W-1:0]  offset;
  logic unusedHi;

  assign fN = instr[INSTR_W-7];
  assign fI = instr[INSTR_W-8];
  assign fX = instr[INSTR_W-9];
  assign fB = instr[INSTR_W-10];
  assign fP = instr[INSTR_W-11];
  assign fE = instr[INSTR_W-12];
  assign disp    = instr[ADDR_W-1 -: DISP_W];
  assign oldAddr = instr[INSTR_W-10 -: OLD_W];
  assign oldFmt  = !fN && !fI;
  assign unusedHi = ^{instr[INSTR_W-1:INSTR_W-6],
                      baseReg[WORD_W-1:ADDR_W], indexReg[WORD_W-1:ADDR_W]};

  assign modeImm = fI && !fN;
  assign modeInd = fN && !fI;
  assign illegal = !oldFmt && ((fX && (modeImm || modeInd)) ||
                               (fB && fP) || (fE && (fB || fP)));

  always_comb begin
    idxAdd = fX ? indexReg[ADDR_W-1:0] : '0;
    if (oldFmt)      rawAddr = ADDR_W'(oldAddr);
    else if (fE)     rawAddr = instr[ADDR_W-1:0];
    else if (fB)     rawAddr = baseReg[ADDR_W-1:0] + ADDR_W'(disp);
    else if (fP)     rawAddr = pc + ADDR_W'(FMT3_LEN) + ADDR_W'(signed'(disp));
    else             rawAddr = ADDR_W'(disp);
    taNext = rawAddr + idxAdd;
  end

  assign wordNext = {wordReg[WORD_W-BYTE_W-1:0], memData};
  assign lastByte = (offset == OFF_W'(BYTES-1));
  assign memAddr  = ptrReg + ADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taReg   <= '0;
      ptrReg  <= '0;
      wordReg <= '0;
      offset  <= '0;
    end else if (strb.load) begin
      taReg   <= taNext;
      ptrReg  <= taNext;
      offset  <= '0;
      wordReg <= (modeImm && !illegal) ? WORD_W'(taNext) : '0;
    end else if (strb.capByte) begin
      wordReg <= wordNext;
      offset  <= lastByte ? '0 : offset + OFF_W'(1);
      if (strb.chain) ptrReg <= wordNext[ADDR_W-1:0];
    end
  end

  assign targetAddr = taReg;
  assign operand    = wordReg;

  // R2: a word is never more than BYTES byte reads
  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    offset <= OFF_W'(BYTES-1));
  // R7: chaining only on the last byte of the pointer word
  assert_chain_on_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.chain |-> lastByte);
endmodule

// File: rtl/ext_fetch_control.sv
module ext_fetch_control
  import ext_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          modeImm,
  input  logic          modeInd,
  input  logic          illegal,
  input  logic          lastByte,
  output fetchStrobes_t strb,
  output logic          memRd,
  output logic          done,
  output logic          err
);
  typedef enum logic [1:0] {ST_IDLE, ST_PTR, ST_OPND} state_t;
  state_t state;

  always_comb begin
    strb.load    = (state == ST_IDLE) && start;
    strb.capByte = (state != ST_IDLE);
    strb.chain   = (state == ST_PTR) && lastByte;
  end
  assign memRd = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (illegal) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else if (modeImm) done <= 1'b1;
          else if (modeInd)     state <= ST_PTR;
          else                  state <= ST_OPND;
        end
        ST_PTR:  if (lastByte) state <= ST_OPND;
        ST_OPND: if (lastByte) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: an error is only reported with a done strobe
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);
  // R2: the result strobe never overlaps a memory read
  assert_no_read_at_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRd);
  // R10: reads begin only right after an accepted start
  assert_read_after_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |-> $past(start));
  // R6: an immediate instruction finishes next cycle without reading
  assert_imm_no_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && modeImm && !illegal) |=> (done && !memRd));
endmodule

// File: rtl/ext_operand_fetch.sv
module ext_operand_fetch
  import ext_fetch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 24,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [WORD_W-1:0]  baseReg,
  input  logic [WORD_W-1:0]  indexReg,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               done,
  output logic               err,
  output logic [ADDR_W-1:0]  targetAddr,
  output logic [WORD_W-1:0]  operand
);
  fetchStrobes_t strb;
  logic modeImm, modeInd, illegal, lastByte;

  ext_fetch_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeImm(modeImm),
    .modeInd(modeInd), .illegal(illegal), .lastByte(lastByte),
    .strb(strb), .memRd(memRd), .done(done), .err(err)
  );

  ext_fetch_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .INSTR_W(INSTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc), .baseReg(baseReg),
    .indexReg(indexReg), .memData(memData), .strb(strb), .modeImm(modeImm),
    .modeInd(modeInd), .illegal(illegal), .lastByte(lastByte),
    .memAddr(memAddr), .targetAddr(targetAddr), .operand(operand)
  );
endmodule

// File: tb/ext_operand_fetch_tb.sv
`timescale 1ns/1ps
module ext_operand_fetch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [19:0] pc = '0;
  logic [23:0] baseReg = '0;
  logic [23:0] indexReg = '0;
  logic        memRd, done, err;
  logic [19:0] memAddr, targetAddr;
  logic [7:0]  memData;
  logic [23:0] operand;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ext_operand_fetch u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .pc(pc),
    .baseReg(baseReg), .indexReg(indexReg), .memRd(memRd), .memAddr(memAddr),
    .memData(memData), .done(done), .err(err), .targetAddr(targetAddr),
    .operand(operand)
  );

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction
  function automatic logic [23:0] memWord(input logic [19:0] a);
    return {memByte(a), memByte(a + 20'd1), memByte(a + 20'd2)};
  endfunction
  assign memData = memByte(memAddr);

  // flags order: n i x b p e ; field is instr[19:0]
  function automatic logic [31:0] mk(input logic [5:0] flg, input logic [19:0] fld);
    return {6'h15, flg, fld};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] ins, input int expK,
                     input logic [19:0] expTa, input logic [23:0] expOp,
                     input bit expErr, input bit expRd);
    int doneAt = -1;
    bit sawRd = 0;
    logic [19:0] ta = '0;
    logic [23:0] op = '0;
    logic er = 1'b0;
    @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 10; c++) begin
      if (doneAt < 0 && memRd) sawRd = 1;
      if (done && doneAt < 0) begin
        doneAt = c; ta = targetAddr; op = operand; er = err;
      end
      if (c < 9) @(negedge clk);
    end
    check(doneAt == expK, {tag, " latency"}, doneAt, expK);
    check(er == expErr, {tag, " err"}, {31'd0, er}, {31'd0, expErr});
    check(sawRd == expRd, {tag, " memRd"}, {31'd0, sawRd}, {31'd0, expRd});
    if (!expErr) check(ta == expTa, {tag, " targetAddr"}, {12'd0, ta}, {12'd0, expTa});
    check(op == expOp, {tag, " operand"}, {8'd0, op}, {8'd0, expOp});
  endtask

  task automatic testReset();
    check(!done && !err && !memRd, "R1 reset outputs",
          {29'd0, done, err, memRd}, 32'd0);
  endtask

  task automatic testDirect();
    indexReg = 24'h001000;
    run("R2 direct", mk(6'b110000, 20'h12300), 3, 20'h00123, memWord(20'h00123), 0, 1);
    run("R2 direct indexed", mk(6'b111000, 20'h12300), 3, 20'h01123,
        memWord(20'h01123), 0, 1);
    run("R2 word wraps", mk(6'b111000, 20'hFFE00), 3, 20'h01FFE,
        memWord(20'h01FFE), 0, 1);
  endtask

  task automatic testBase();
    baseReg = 24'hA0FF00;
    run("R3 base unsigned disp", mk(6'b110100, 20'hFFF00), 3, 20'h10EFF,
        memWord(20'h10EFF), 0, 1);
  endtask

  task automatic testPcRel();
    pc = 20'h02000;
    run("R4 pc negative", mk(6'b110010, 20'hFFE00), 3, 20'h02001,
        memWord(20'h02001), 0, 1);
    pc = 20'hFFFF0;
    run("R4 pc wrap", mk(6'b110010, 20'h01000), 3, 20'h00003,
        memWord(20'h00003), 0, 1);
  endtask

  task automatic testExtended();
    indexReg = 24'hF00022;
    run("R5 extended indexed", mk(6'b111001, 20'hABCDE), 3, 20'hABD00,
        memWord(20'hABD00), 0, 1);
  endtask

  task automatic testImmediate();
    run("R6 immediate fmt3", mk(6'b010000, 20'h7FF00), 0, 20'h007FF, 24'h0007FF, 0, 0);
    run("R6 immediate extended", mk(6'b010001, 20'hFFFFF), 0, 20'hFFFFF,
        24'h0FFFFF, 0, 0);
  endtask

  task automatic testIndirect();
    logic [19:0] ptr;
    ptr = memWord(20'h00200);
    run("R7 indirect", mk(6'b100000, 20'h20000), 6, 20'h00200, memWord(ptr), 0, 1);
  endtask

  task automatic testOldFormat();
    indexReg = 24'h000010;
    // x=1 and instr[22:8]=15'h7ABC
    run("R8 old format", {6'h15, 2'b00, 1'b1, 15'h7ABC, 8'h00}, 3, 20'h07ACC,
        memWord(20'h07ACC), 0, 1);
  endtask

  task automatic testIllegal();
    run("R9 index with immediate", mk(6'b011000, 20'h00100), 0, 20'h0, 24'h0, 1, 0);
    run("R9 b and p", mk(6'b110110, 20'h00100), 0, 20'h0, 24'h0, 1, 0);
    run("R9 extended with p", mk(6'b110011, 20'h00100), 0, 20'h0, 24'h0, 1, 0);
  endtask

  task automatic testBusy();
    int dones = 0;
    logic [23:0] op = '0;
    logic [19:0] ta = '0;
    @(negedge clk);
    instr = mk(6'b110000, 20'h04000);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr = mk(6'b010000, 20'h55500);
    for (int c = 0; c < 10; c++) begin
      if (done) begin dones++; op = operand; ta = targetAddr; end
      if (c == 1) start = 1'b0;
      @(negedge clk);
    end
    check(dones == 1, "R10 single done", dones, 1);
    check(ta == 20'h00040, "R10 first address kept", {12'd0, ta}, 32'h40);
    check(op == memWord(20'h00040), "R10 first operand kept", {8'd0, op},
          {8'd0, memWord(20'h00040)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirect();
    testBase();
    testPcRel();
    testExtended();
    testImmediate();
    testIndirect();
    testOldFormat();
    testIllegal();
    testBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule